// File: doc/BRIEF.md
# Frame-Locked Clock Prescaler

This block receives a conversion clock that runs at one of five fixed rates (128 kHz, 1.536 MHz, 1.544 MHz, 2.048 MHz or 2.56 MHz) together with an 8 kHz frame sync. It never needs to be told which rate is present. It counts conversion-clock cycles from one rising frame-sync edge to the next, classifies the count, and once two consecutive frames agree it divides the conversion clock into a 128 kHz sequencing enable: 16 one-cycle pulses per frame.

The pulse train restarts in phase with every frame-sync rising edge. Each frame therefore carries at most 16 enables, and any surplus cycles at the end of a frame stay idle. For the 1.544 MHz case, which gives 193 cycles per frame, the divide ratio is 12 and the 193rd cycle is absorbed. At 128 kHz the clock passes straight through with a ratio of 1.

All logic runs on the conversion clock. The frame sync is resynchronised into that domain. The block publishes the detected rate code and a valid flag. The flag drops when the frame period leaves the accepted windows, or when the frame sync stops.

Top module: `frame_locked_prescaler`

## Requirements
- R1: After reset, `rate_valid` is 0, `seq_en` is 0 and `rate_code` is 7 (no rate).
- R2: A measured frame period of 15–17 cycles maps to code 0, 191–192 to code 1, 193–194 to code 2, 255–257 to code 3 and 319–321 to code 4. Any other period gives code 7. While `rate_valid` is 1, `rate_code` holds the code of the locked rate. Otherwise it reads 7.
- R3: `rate_valid` rises when two consecutive measured periods fall into the same accepted window. It takes effect on the same clock edge that restarts the pulse train for that frame.
- R4: While locked, successive enables in a frame are spaced by the divide ratio: 1 cycle for code 0, 12 for codes 1 and 2, 16 for code 3 and 20 for code 4.
- R5: A frame carries at most 16 enables. Cycles of the frame that remain after the 16th enable (such as the 193rd cycle at code 2) produce none.
- R6: The first enable of a frame is high in the cycle that begins at the second clock edge after the edge that first samples `frame_sync` high.
- R7: `seq_en` stays 0 whenever `rate_valid` is 0.
- R8: A frame period outside every accepted window never yields `rate_valid`, so no enables are produced.
- R9: If no rising `frame_sync` arrives, `rate_valid` falls at the clock edge TIMEOUT_CYCLES+2 edges after the edge that first sampled the last `frame_sync` high, and `rate_code` returns to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, one of the five supported rates |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | 8 kHz frame sync, asynchronous to `clk` |
| seq_en | output | 1 | One-cycle sequencing enable, 16 per locked frame |
| rate_code | output | 3 | Detected rate code (0–4), 7 when unlocked |
| rate_valid | output | 1 | Rate locked and enables running |

## Verification
The bench instantiates the block with TIMEOUT_CYCLES set to 400 and PULSES_PER_FRAME left at 16. This keeps each loss-of-sync tail short while staying above the longest accepted period of 321 cycles. Frame periods are swept across all five nominal counts, the window edges (15, 191, 257, 321) and an unaccepted period of 100. Every cycle of every run is compared with an enable, valid and code pattern computed arithmetically from the period. This covers locking, pulse spacing, the surplus-cycle idle time and the timeout drop for every rate.

// File: rtl/flp_pkg.sv
// Package: shared rate type and rate arithmetic for the frame-locked prescaler.
// Assumes an 8 kHz frame and a 128 kHz sequencing target.
package flp_pkg;

    typedef enum logic [2:0] {
        RATE_128K  = 3'd0,
        RATE_1M536 = 3'd1,
        RATE_1M544 = 3'd2,
        RATE_2M048 = 3'd3,
        RATE_2M560 = 3'd4,
        RATE_NONE  = 3'd7
    } rate_e;

    localparam int MAX_RATIO = 20;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    // Map a measured frame period (in clock cycles) onto a rate class.
    function automatic rate_e classify_period(input int unsigned n);
        if (n >= 15 && n <= 17)        return RATE_128K;
        else if (n >= 191 && n <= 192) return RATE_1M536;
        else if (n >= 193 && n <= 194) return RATE_1M544;
        else if (n >= 255 && n <= 257) return RATE_2M048;
        else if (n >= 319 && n <= 321) return RATE_2M560;
        else                           return RATE_NONE;
    endfunction

    // Divide ratio that turns a rate class into 128 kHz.
    function automatic logic [RATIO_W-1:0] rate_ratio(input rate_e r);
        case (r)
            RATE_1M536: return RATIO_W'(12);
            RATE_1M544: return RATIO_W'(12);
            RATE_2M048: return RATIO_W'(16);
            RATE_2M560: return RATIO_W'(20);
            default:    return RATIO_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/flp_sync_edge.sv
// Module: brings the asynchronous frame sync into the clock domain with two
// flops and flags its rising edge for one cycle.
// Assumes frame_sync stays high for at least two clock cycles per frame.
module flp_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] stage_q;

    // Shift the async input through the synchroniser and an edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= 3'b000;
        else        stage_q <= {stage_q[1:0], async_i};
    end

    assign rise_o = stage_q[1] & ~stage_q[2];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R6

endmodule

// File: rtl/flp_rate_detect.sv
// Module: measures clock cycles between frame-sync edges, classifies the
// period, and declares lock after two consecutive agreeing frames.
// Assumes rise_i is a one-cycle pulse; the first edge after reset or a
// timeout only arms the measurement.
module flp_rate_detect
    import flp_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 512
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise_i,
    output logic  valid_o,
    output rate_e code_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

    logic [CNT_W-1:0] per_cnt_q;
    logic             armed_q;
    rate_e            prev_q;
    rate_e            cur_rate;

    // Classify the period that closes at this edge.
    always_comb cur_rate = classify_period(32'(per_cnt_q));

    // Period counter, lock history and timeout handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt_q <= '0;
            armed_q   <= 1'b0;
            prev_q    <= RATE_NONE;
            valid_o   <= 1'b0;
            code_o    <= RATE_NONE;
        end else if (rise_i) begin
            per_cnt_q <= CNT_W'(1);
            armed_q   <= 1'b1;
            if (armed_q) begin
                prev_q <= cur_rate;
                if (cur_rate != RATE_NONE && cur_rate == prev_q) begin
                    valid_o <= 1'b1;
                    code_o  <= cur_rate;
                end else begin
                    valid_o <= 1'b0;
                    code_o  <= RATE_NONE;
                end
            end else begin
                prev_q <= RATE_NONE;
            end
        end else if (per_cnt_q == CNT_W'(TIMEOUT_CYCLES)) begin
            armed_q <= 1'b0;
            prev_q  <= RATE_NONE;
            valid_o <= 1'b0;
            code_o  <= RATE_NONE;
        end else begin
            per_cnt_q <= per_cnt_q + 1'b1;
        end
    end

    AST_LOCK_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(rise_i)); // R3
    AST_CODE_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> code_o != RATE_NONE); // R2
    AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cnt_q == CNT_W'(TIMEOUT_CYCLES) && !rise_i) |=> !valid_o); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt_q <= CNT_W'(TIMEOUT_CYCLES)); // R9

endmodule

// File: rtl/flp_seq_divider.sv
// Module: divides the clock by ratio_i and emits up to PULSES enables per
// frame, restarting phase on restart_i; surplus cycles stay idle.
// Assumes ratio_i is at least 1 and changes only at a restart.
module flp_seq_divider
    import flp_pkg::*;
#(
    parameter int PULSES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               lock_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               seq_en_o
);
    localparam int NP_W = $clog2(PULSES + 1);

    logic [RATIO_W-1:0] phase_q;
    logic [NP_W-1:0]    npulse_q;
    logic               burst_live;

    assign burst_live = (npulse_q < NP_W'(PULSES));

    // Phase and pulse counters, realigned at every frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            npulse_q <= NP_W'(PULSES);
        end else if (restart_i) begin
            phase_q  <= '0;
            npulse_q <= '0;
        end else if (burst_live) begin
            if (phase_q == ratio_i - 1'b1) begin
                phase_q  <= '0;
                npulse_q <= npulse_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign seq_en_o = lock_i && burst_live && (phase_q == '0);

    AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en_o && ratio_i > RATIO_W'(1) && !restart_i) |=> !seq_en_o); // R4
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        npulse_q <= NP_W'(PULSES)); // R5

endmodule

// File: rtl/frame_locked_prescaler.sv
// Module: top of the frame-locked prescaler. Resynchronises the frame sync,
// detects the conversion-clock rate and produces the 128 kHz sequencing
// enable. Assumes clk is the conversion clock itself.
module frame_locked_prescaler
    import flp_pkg::*;
#(
    parameter int TIMEOUT_CYCLES   = 512,
    parameter int PULSES_PER_FRAME = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    output logic       seq_en,
    output logic [2:0] rate_code,
    output logic       rate_valid
);
    logic               fs_rise;
    logic               lock;
    rate_e              code;
    logic [RATIO_W-1:0] ratio;

    flp_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (frame_sync),
        .rise_o  (fs_rise)
    );

    flp_rate_detect #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (fs_rise),
        .valid_o (lock),
        .code_o  (code)
    );

    assign ratio = rate_ratio(code);

    flp_seq_divider #(.PULSES(PULSES_PER_FRAME)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (fs_rise),
        .lock_i    (lock),
        .ratio_i   (ratio),
        .seq_en_o  (seq_en)
    );

    assign rate_code  = code;
    assign rate_valid = lock;

    AST_LOCK_STARTS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_valid) |-> seq_en); // R6
    AST_NO_EN_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_valid |-> !seq_en); // R7

endmodule

// File: tb/frame_locked_prescaler_bench.sv
module frame_locked_prescaler_bench;
    localparam int TMO = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       seq_en;
    logic [2:0] rate_code;
    logic       rate_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    frame_locked_prescaler #(.TIMEOUT_CYCLES(TMO), .PULSES_PER_FRAME(16)) u_frame_locked_prescaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .seq_en     (seq_en),
        .rate_code  (rate_code),
        .rate_valid (rate_valid)
    );

    task automatic check(input string req, input int t, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
        end
    endtask

    // Code and ratio for a period, straight from R2 and R4.
    function automatic int exp_code(input int n);
        if (n >= 15 && n <= 17)   return 0;
        if (n >= 191 && n <= 192) return 1;
        if (n >= 193 && n <= 194) return 2;
        if (n >= 255 && n <= 257) return 3;
        if (n >= 319 && n <= 321) return 4;
        return 7;
    endfunction

    function automatic int exp_ratio(input int c);
        case (c)
            1, 2: return 12;
            3:    return 16;
            4:    return 20;
            default: return 1;
        endcase
    endfunction

    // Reset, run FR frames of period N, then let the sync stop and time out.
    task automatic run_period(input int n, input int fr);
        int code  = exp_code(n);
        int ratio = exp_ratio(code);
        int last  = (fr - 1) * n;
        int drop  = last + TMO + 3;
        rst_n = 1'b0;
        frame_sync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t <= drop + 3; t++) begin
            @(negedge clk);
            begin
                bit ev;
                bit ee;
                int f;
                int rel;
                ev = (code != 7) && (t >= 2 * n + 3) && (t < drop);
                ee = 1'b0;
                if (ev) begin
                    f = (t - 3) / n;
                    if (f > fr - 1) f = fr - 1;
                    rel = t - 3 - f * n;
                    ee = (rel % ratio == 0) && (rel / ratio < 16);
                end
                if (t < 2) begin
                    check("R1 valid", t, int'(rate_valid), 0);
                    check("R1 code", t, int'(rate_code), 7);
                    check("R1 seq_en", t, int'(seq_en), 0);
                end else begin
                    check(code == 7 ? "R8 valid" : (t >= drop - 1 ? "R9 valid" : "R3 valid"),
                          t, int'(rate_valid), int'(ev));
                    check(t >= drop ? "R9 code" : "R2 code", t, int'(rate_code), ev ? code : 7);
                    if (!ev)
                        check("R7 seq_en", t, int'(seq_en), 0);
                    else if (((t - 3) % n) == 0)
                        check("R6 seq_en", t, int'(seq_en), int'(ee));
                    else if (ee)
                        check("R4 seq_en", t, int'(seq_en), 1);
                    else
                        check("R5 seq_en", t, int'(seq_en), 0);
                end
            end
            frame_sync = (t < fr * n) && ((t % n) < 4);
        end
    endtask

    initial begin
        run_period(16, 5);
        run_period(192, 4);
        run_period(193, 4);
        run_period(256, 4);
        run_period(320, 4);
        run_period(15, 5);
        run_period(191, 4);
        run_period(257, 4);
        run_period(321, 4);
        run_period(100, 5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule